// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a chain of 4-bit counting digits that all change on the rising clock edge. Each digit can be preset from a parallel data input, cleared, made to count, or made to hold. Two count enables control counting. One of them, the wide-path enable, also qualifies the digit's terminal-count carry. That carry drives the wide-path enable of the next digit, so wider counters need no extra glue. The other enable, the local enable, is shared by every digit.

Two parameters configure the block. One selects binary digits (modulo 16) or decade digits (modulo 10). The other selects whether the active-low clear acts at once or waits for the next clock edge. With synchronous clear, decoding the outputs into the clear input shortens the count cycle.

The block is used as a plain synchronous counter, a programmable divider, or the low part of a wider cascaded count.

Top module: `cnt_chain`

## Requirements
- R1: With asynchronous clear selected, a low `clr_n` drives every output bit to 0 at once, without waiting for a clock edge, and holds it there whatever `load_n` and the enables do.
- R2: With synchronous clear selected, a low `clr_n` at a rising edge makes every output bit 0 after that edge. It takes priority over `load_n`, `en_p` and `en_t`.
- R3: With clear inactive and `load_n` low at a rising edge, `q` takes the value of `din` after that edge, whatever the levels of `en_p` and `en_t`.
- R4: With clear and load inactive and both `en_p` and `en_t` high at a rising edge, the lowest digit steps by one. A binary digit wraps from 15 to 0.
- R5: With clear and load inactive and either enable low at a rising edge, `q` keeps its value.
- R6: A decade digit steps from 9 to 0. A decade digit preset to a value from 10 to 15 counts up to 15 and then to 0.
- R7: `carry_out` is 1 exactly when `en_t` is 1 and every digit holds its maximum (15 binary, 9 decade). It follows `en_t` without a clock edge, and a decade digit at 15 gives no carry.
- R8: Each digit's carry feeds the next digit's wide-path enable and `en_p` is shared by all digits, so in binary mode the whole `q` counts modulo 16^STAGES, crossing digit boundaries in a single edge.
- R9: With synchronous clear, driving `clr_n` low while `q` equals K gives a repeating count 0, 1, …, K, 0, a cycle of K+1 states.
- R10: Only the enable levels at the rising edge matter. An enable pulse that starts and ends between two edges causes no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all digits |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous per `SYNC_CLR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Local count enable, shared by all digits |
| en_t | input | 1 | Wide-path count enable into the lowest digit, also qualifies the carry |
| din | input | 4*STAGES | Parallel preset value |
| q | output | 4*STAGES | Counter state |
| carry_out | output | 1 | Terminal-count carry of the highest digit |

## Verification
A wrong state register shows at `q` after the first rising edge that follows the faulty update. A wrong carry decode shows at `carry_out` in the same cycle, because the carry is combinational from the state and `en_t`. A broken cascade appears as a wrong upper digit on the edge where the lower digit wraps, so every test crosses at least one digit boundary. A wrong action priority shows one edge later, when clear, load and the enables are driven together and `q` is compared with a reference model in the bench. A wrong asynchronous clear shows within a fraction of a clock period, with no edge needed.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

  // highest value a digit reaches before it carries
  function automatic logic [DIGIT_W-1:0] digit_top(input bit decade);
    return decade ? DIGIT_W'(9) : {DIGIT_W{1'b1}};
  endfunction

  // next value of a counting digit; a decade digit above 9 runs on to 15, then 0
  function automatic logic [DIGIT_W-1:0] digit_step(input bit decade,
                                                   input logic [DIGIT_W-1:0] v);
    if (decade && v == DIGIT_W'(9)) return '0;
    return v + DIGIT_W'(1);
  endfunction
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl #(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          en_p,
  input  logic          en_t,
  output cnt_pkg::act_e act
);
  import cnt_pkg::*;

  logic clr_req;
  assign clr_req = SYNC_CLR && !clr_n;

  // priority: clear, load, count, hold
  always_comb begin
    if (clr_req)          act = ACT_CLEAR;
    else if (!load_n)     act = ACT_LOAD;
    else if (en_p && en_t) act = ACT_COUNT;
    else                  act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter bit DECADE   = 1'b0,
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic                        en_p,
  input  logic                        en_t,
  input  logic [cnt_pkg::DIGIT_W-1:0] d,
  output logic [cnt_pkg::DIGIT_W-1:0] q,
  output logic                        rco
);
  import cnt_pkg::*;

  act_e               act;
  logic [DIGIT_W-1:0] state;
  logic [DIGIT_W-1:0] nxt;
  logic               at_top;

  cnt_ctrl #(.SYNC_CLR(SYNC_CLR)) u_ctrl (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .act   (act)
  );

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = d;
      ACT_COUNT: nxt = digit_step(DECADE, state);
      default:   nxt = state;
    endcase
  end

  generate
    if (SYNC_CLR) begin : g_sync
      always_ff @(posedge clk) state <= nxt;
    end else begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state <= '0;
        else        state <= nxt;
      end
    end
  endgenerate

  assign at_top = (state == digit_top(DECADE));
  assign rco    = at_top && en_t;
  assign q      = state;
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int STAGES   = 2,
  parameter bit DECADE   = 1'b0,
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic                               clk,
  input  logic                               clr_n,
  input  logic                               load_n,
  input  logic                               en_p,
  input  logic                               en_t,
  input  logic [cnt_pkg::DIGIT_W*STAGES-1:0] din,
  output logic [cnt_pkg::DIGIT_W*STAGES-1:0] q,
  output logic                               carry_out
);
  import cnt_pkg::*;

  localparam int W = DIGIT_W * STAGES;

  // wide-path enable handed from digit to digit
  logic [STAGES:0] t_link;
  assign t_link[0] = en_t;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_digit
      cnt_stage #(.DECADE(DECADE), .SYNC_CLR(SYNC_CLR)) u_stage (
        .clk   (clk),
        .clr_n (clr_n),
        .load_n(load_n),
        .en_p  (en_p),
        .en_t  (t_link[i]),
        .d     (din[i*DIGIT_W +: DIGIT_W]),
        .q     (q[i*DIGIT_W +: DIGIT_W]),
        .rco   (t_link[i+1])
      );
    end
  endgenerate

  assign carry_out = t_link[STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int STAGES   = 2,
  parameter bit DECADE   = 1'b0,
  parameter bit SYNC_CLR = 1'b1
) (
  input logic                   clk,
  input logic                   clr_n,
  input logic                   load_n,
  input logic                   en_p,
  input logic                   en_t,
  input logic [4*STAGES-1:0]    din,
  input logic [4*STAGES-1:0]    q,
  input logic                   carry_out
);
  localparam int W = 4 * STAGES;
  localparam logic [3:0] LOW_TOP = DECADE ? 4'd9 : 4'd15;

  generate
    if (SYNC_CLR) begin : g_sc
      // R2
      sync_clear_chk: assert property (@(posedge clk) !clr_n |=> q == '0);
    end else begin : g_ac
      // R1
      async_clear_chk: assert property (@(posedge clk) !clr_n |-> q == '0);
    end
    if (!DECADE) begin : g_bin
      // R8
      chain_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> q == W'($past(q) + 1'b1));
    end
  endgenerate

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R4
  low_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=>
      q[3:0] == ((DECADE && $past(q[3:0]) == 4'd9) ? 4'd0 : 4'($past(q[3:0]) + 4'd1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R7
  carry_qual_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (en_t && q[3:0] == LOW_TOP));
endmodule

bind cnt_chain cnt_chain_chk #(.STAGES(STAGES), .DECADE(DECADE), .SYNC_CLR(SYNC_CLR)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .en_p     (en_p),
  .en_t     (en_t),
  .din      (din),
  .q        (q),
  .carry_out(carry_out)
);

// File: tb/cnt_chain_test.sv
`timescale 1ns/100ps
module cnt_chain_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // binary, synchronous clear, two digits
  logic       clr_a_drv, fb_on, load_a, enp_a, ent_a;
  logic [7:0] din_a, q_a;
  logic       co_a, clr_a;
  localparam logic [7:0] K = 8'd5;
  assign clr_a = clr_a_drv & ~(fb_on && q_a == K);

  cnt_chain #(.STAGES(2), .DECADE(1'b0), .SYNC_CLR(1'b1)) uut (
    .clk(clk), .clr_n(clr_a), .load_n(load_a), .en_p(enp_a), .en_t(ent_a),
    .din(din_a), .q(q_a), .carry_out(co_a));

  // decade, asynchronous clear, one digit
  logic       clr_d, load_d, enp_d, ent_d;
  logic [3:0] din_d, q_d;
  logic       co_d;

  cnt_chain #(.STAGES(1), .DECADE(1'b1), .SYNC_CLR(1'b0)) uut_dec (
    .clk(clk), .clr_n(clr_d), .load_n(load_d), .en_p(enp_d), .en_t(ent_d),
    .din(din_d), .q(q_d), .carry_out(co_d));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clr_a_drv = 0; clr_d = 0;
    tick(); tick();
    check("R2 reset q", q_a, 0);
    check("R1 reset q", q_d, 0);
    check("R7 reset carry", co_a, 0);
    clr_a_drv = 1; clr_d = 1;
  endtask

  task automatic t_load();
    load_a = 0; enp_a = 0; ent_a = 0; din_a = 8'hA5;
    tick(); check("R3 load enables low", q_a, 8'hA5);
    enp_a = 1; ent_a = 1; din_a = 8'h3C;
    tick(); check("R3 load enables high", q_a, 8'h3C);
    load_a = 1;
  endtask

  task automatic t_count();
    logic [7:0] e = 8'h3C;
    enp_a = 1; ent_a = 1;
    for (int n = 0; n < 6; n++) begin
      tick(); e = e + 8'd1;
      check("R4 R8 count across digits", q_a, e);
    end
  endtask

  task automatic t_hold();
    logic [7:0] h = q_a;
    enp_a = 0; ent_a = 1;
    tick(); tick(); check("R5 hold en_p low", q_a, h);
    enp_a = 1; ent_a = 0;
    tick(); check("R5 hold en_t low", q_a, h);
    ent_a = 1; enp_a = 1; #0.5; enp_a = 0;
    tick(); check("R10 pulse between edges", q_a, h);
  endtask

  task automatic t_carry();
    load_a = 0; enp_a = 0; ent_a = 1; din_a = 8'hFE;
    tick(); load_a = 1; #0.5;
    check("R7 no carry at FE", co_a, 0);
    load_a = 0; din_a = 8'hFF;
    tick(); load_a = 1; #0.5;
    check("R7 carry at FF", co_a, 1);
    ent_a = 0; #0.5; check("R7 carry follows en_t low", co_a, 0);
    ent_a = 1; #0.5; check("R7 carry follows en_t high", co_a, 1);
    enp_a = 1;
    tick(); check("R8 wrap modulo 256", q_a, 8'h00);
    check("R7 carry after wrap", co_a, 0);
  endtask

  task automatic t_sync_clear();
    load_a = 0; din_a = 8'h77;
    tick(); check("R3 preset before clear", q_a, 8'h77);
    clr_a_drv = 0; enp_a = 1; ent_a = 1; din_a = 8'h99;
    #0.5; check("R2 no clear before edge", q_a, 8'h77);
    tick(); check("R2 clear beats load and enables", q_a, 8'h00);
    clr_a_drv = 1; load_a = 1;
  endtask

  task automatic t_trunc();
    logic [7:0] e = 0;
    load_a = 0; din_a = 0; tick();
    load_a = 1; enp_a = 1; ent_a = 1; fb_on = 1;
    for (int n = 0; n < 14; n++) begin
      tick(); e = (e == K) ? 8'd0 : e + 8'd1;
      check("R9 truncated count", q_a, e);
    end
    fb_on = 0;
  endtask

  task automatic t_decade();
    load_d = 0; enp_d = 1; ent_d = 1; din_d = 4'd7;
    tick(); check("R3 decade load", q_d, 7);
    load_d = 1;
    tick(); check("R6 decade 8", q_d, 8);
    tick(); check("R6 decade 9", q_d, 9);
    check("R7 decade carry at 9", co_d, 1);
    tick(); check("R6 decade 9 to 0", q_d, 0);
    check("R7 decade carry at 0", co_d, 0);
    load_d = 0; din_d = 4'd13;
    tick(); load_d = 1; check("R6 preset 13", q_d, 13);
    tick(); check("R6 14", q_d, 14);
    tick(); check("R6 15", q_d, 15);
    check("R7 no carry at 15", co_d, 0);
    tick(); check("R6 15 to 0", q_d, 0);
  endtask

  task automatic t_async();
    load_d = 0; din_d = 4'd6;
    tick(); check("R3 decade preset", q_d, 6);
    clr_d = 0; #0.5;
    check("R1 clear without edge", q_d, 0);
    tick(); check("R1 clear held over load", q_d, 0);
    clr_d = 1; load_d = 1;
  endtask

  initial begin
    fb_on = 0; clr_a_drv = 0; load_a = 1; enp_a = 0; ent_a = 0; din_a = 0;
    clr_d = 0; load_d = 1; enp_d = 0; ent_d = 0; din_d = 0;
    t_reset();
    t_load();
    t_count();
    t_hold();
    t_carry();
    t_sync_clear();
    t_trunc();
    t_decade();
    t_async();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule